// File: doc/BRIEF.md
# Hint-Directed Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Every branch carries a two-bit hint chosen by the compiler. Two of the hint values are static: they fix the prediction outright, and the block never keeps state for such branches. The other two values are dynamic. A dynamic branch looks up a small direct-mapped history table of two-bit saturating counters. When its entry is absent, the branch falls back to the direction that the hint names.

The fetch stage drives a lookup port with the branch PC and its hint. It gets back a combinational prediction and a flag that shows whether a table entry supplied it. The execute stage drives an update port with the PC, the hint and the resolved direction. The table changes on the following clock edge. A lookup in the same cycle as an update therefore sees the table as it stood before that update. Table slots are selected by PC bits [5:2]. The remaining upper PC bits form the tag.

Top module: `hint_branch_predictor`

## Requirements
- R1: Hint code 2'b00 (static, taken) always gives lk_taken=1 and lk_hit=0, whatever the table holds.
- R2: Hint code 2'b01 (static, not taken) always gives lk_taken=0 and lk_hit=0, whatever the table holds.
- R3: A lookup with a dynamic hint (2'b10 default taken, 2'b11 default not taken) whose slot is invalid or holds another tag gives lk_hit=0 and lk_taken equal to the hint default (1 for 2'b10, 0 for 2'b11).
- R4: An update carrying a static hint (2'b00 or 2'b01) changes no table slot. A later dynamic lookup of the same PC still misses.
- R5: A dynamic update that misses claims the slot with the new tag. Its counter starts at 2'b10 when the branch was taken and at 2'b01 when it was not.
- R6: A dynamic update that hits moves the counter up by one when taken and down by one when not taken. The counter saturates at 2'b11 and at 2'b00.
- R7: A dynamic lookup that hits gives lk_hit=1 and lk_taken equal to bit 1 of the slot counter, regardless of the hint default.
- R8: The slot index is PC[5:2] and the tag is PC[31:6]. Two PCs that share an index but differ in tag do not hit each other's entry, and a missing dynamic update replaces the older entry.
- R9: When a lookup and an update touch the same slot in one cycle, the lookup reflects the state before the update. The update is visible from the next cycle.
- R10: After reset every slot is invalid, so all dynamic lookups miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | 32 | PC of the branch being predicted |
| lk_hint | input | 2 | Hint of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hit | output | 1 | Prediction came from a valid, tag-matching table slot |
| up_valid | input | 1 | Update strobe |
| up_pc | input | 32 | PC of the resolved branch |
| up_hint | input | 2 | Hint of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The hardest case to reach is a lookup and an update on the same slot in the same cycle, at a moment when the update changes the predicted direction. Only then does the pre-update ordering show at the outputs. A directed sequence sets a slot to weakly not taken. It then issues a taken update together with a lookup of that slot, and checks the old direction in that cycle and the new one in the next. Random traffic draws PCs from only three tags over the sixteen slots. This keeps hits, tag conflicts, evictions and same-slot collisions frequent. Its static hints are mixed in to show that they never disturb the table.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    HINT_FIX_TK = 2'b00,
    HINT_FIX_NT = 2'b01,
    HINT_DYN_TK = 2'b10,
    HINT_DYN_NT = 2'b11
  } hint_e;

  localparam int unsigned CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_MAX     = '1;
  localparam logic [CTR_W-1:0] CTR_MIN     = '0;
  localparam logic [CTR_W-1:0] CTR_WEAK_TK = 2'b10;
  localparam logic [CTR_W-1:0] CTR_WEAK_NT = 2'b01;

  function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] c,
                                                input logic taken);
    logic [CTR_W-1:0] r;
    r = c;
    if (taken) begin
      if (c != CTR_MAX) r = c + 1'b1;
    end else begin
      if (c != CTR_MIN) r = c - 1'b1;
    end
    return r;
  endfunction

  function automatic logic [CTR_W-1:0] ctr_seed(input logic taken);
    return taken ? CTR_WEAK_TK : CTR_WEAK_NT;
  endfunction

endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bp_hint_decode.sv
module bp_hint_decode
  import bp_pkg::*;
(
  input  logic [1:0] hint,
  output logic       is_dyn,
  output logic       dflt_taken
);
  hint_e h;

  always_comb begin
    h = hint_e'(hint);
    unique case (h)
      HINT_FIX_TK: begin is_dyn = 1'b0; dflt_taken = 1'b1; end
      HINT_FIX_NT: begin is_dyn = 1'b0; dflt_taken = 1'b0; end
      HINT_DYN_TK: begin is_dyn = 1'b1; dflt_taken = 1'b1; end
      default:     begin is_dyn = 1'b1; dflt_taken = 1'b0; end
    endcase
  end
endmodule

// File: rtl/bp_entry.sv
module bp_entry
  import bp_pkg::*;
#(
  parameter int unsigned TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_taken,
  output logic             vld,
  output logic [TAG_W-1:0] tag,
  output logic [CTR_W-1:0] ctr
);
  logic             vld_q, vld_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [CTR_W-1:0] ctr_q, ctr_d;
  logic             wr_hit;

  always_comb begin
    wr_hit = vld_q && (tag_q == wr_tag);
    vld_d  = 1'b1;
    tag_d  = wr_tag;
    ctr_d  = wr_hit ? ctr_step(ctr_q, wr_taken) : ctr_seed(wr_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      ctr_q <= CTR_WEAK_NT;
    end else if (wr_en) begin
      vld_q <= vld_d;
      tag_q <= tag_d;
      ctr_q <= ctr_d;
    end
  end

  assign vld = vld_q;
  assign tag = tag_q;
  assign ctr = ctr_q;

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q) && $stable(tag_q) && $stable(ctr_q));

  // R5
  seed_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> vld_q && (ctr_q == (($past(wr_taken)) ? 2'b10 : 2'b01)));

  // R6
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit && wr_taken && ctr_q == 2'b11) |=> ctr_q == 2'b11);

  // R6
  sat_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit && !wr_taken && ctr_q == 2'b00) |=> ctr_q == 2'b00);
endmodule

// File: rtl/hint_branch_predictor.sv
module hint_branch_predictor
  import bp_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  input  logic [1:0]      lk_hint,
  output logic            lk_taken,
  output logic            lk_hit,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic [1:0]      up_hint,
  input  logic            up_taken
);
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned IDX_LO  = 2;
  localparam int unsigned TAG_LO  = IDX_LO + IDX_W;
  localparam int unsigned TAG_W   = PC_W - TAG_LO;

  logic rst_s;

  bp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  logic lk_dyn, lk_dflt, up_dyn, up_dflt;

  bp_hint_decode u_lk_dec (.hint(lk_hint), .is_dyn(lk_dyn), .dflt_taken(lk_dflt));
  bp_hint_decode u_up_dec (.hint(up_hint), .is_dyn(up_dyn), .dflt_taken(up_dflt));

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [1:0]       pc_low_unused;

  assign lk_idx = lk_pc[TAG_LO-1:IDX_LO];
  assign up_idx = up_pc[TAG_LO-1:IDX_LO];
  assign lk_tag = lk_pc[PC_W-1:TAG_LO];
  assign up_tag = up_pc[PC_W-1:TAG_LO];
  assign pc_low_unused = lk_pc[1:0] ^ up_pc[1:0] ^ {1'b0, up_dflt};

  logic [ENTRIES-1:0] wr_vec;
  logic               ent_vld [ENTRIES];
  logic [TAG_W-1:0]   ent_tag [ENTRIES];
  logic [CTR_W-1:0]   ent_ctr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign wr_vec[g] = up_valid && up_dyn && (up_idx == IDX_W'(g));
    bp_entry #(.TAG_W(TAG_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_s),
      .wr_en    (wr_vec[g]),
      .wr_tag   (up_tag),
      .wr_taken (up_taken),
      .vld      (ent_vld[g]),
      .tag      (ent_tag[g]),
      .ctr      (ent_ctr[g])
    );
  end

  logic             sel_vld;
  logic [TAG_W-1:0] sel_tag;
  logic [CTR_W-1:0] sel_ctr;
  logic             hit_c;

  always_comb begin
    sel_vld  = ent_vld[lk_idx];
    sel_tag  = ent_tag[lk_idx];
    sel_ctr  = ent_ctr[lk_idx];
    hit_c    = lk_dyn && sel_vld && (sel_tag == lk_tag);
    lk_hit   = hit_c;
    lk_taken = hit_c ? sel_ctr[CTR_W-1] : lk_dflt;
  end

  // R1
  fix_taken_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (lk_hint == 2'b00) |-> (lk_taken && !lk_hit));

  // R2
  fix_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (lk_hint == 2'b01) |-> (!lk_taken && !lk_hit));

  // R3
  miss_default_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (lk_hint[1] && !lk_hit) |-> (lk_taken == !lk_hint[0]));

  // R4
  static_no_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (up_valid && !up_hint[1]) |-> (wr_vec == '0));

  // R8
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(wr_vec));
endmodule

// File: tb/hint_branch_predictor_test.sv
`timescale 1ns/1ps
module hint_branch_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc, up_pc;
  logic [1:0]  lk_hint, up_hint;
  logic        lk_taken, lk_hit, up_valid, up_taken;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        rv [16];
  logic [25:0] rt [16];
  logic [1:0]  rc [16];

  always #10 clk = ~clk;

  hint_branch_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hint(lk_hint), .lk_taken(lk_taken), .lk_hit(lk_hit),
    .up_valid(up_valid), .up_pc(up_pc), .up_hint(up_hint), .up_taken(up_taken)
  );

  function automatic logic [31:0] mkpc(input logic [25:0] tg, input logic [3:0] ix);
    return {tg, ix, 2'b00};
  endfunction

  function automatic logic exp_hit(input logic [31:0] pc, input logic [1:0] h);
    return h[1] && rv[pc[5:2]] && (rt[pc[5:2]] == pc[31:6]);
  endfunction

  function automatic logic exp_taken(input logic [31:0] pc, input logic [1:0] h);
    return exp_hit(pc, h) ? rc[pc[5:2]][1] : !h[0];
  endfunction

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] lpc, input logic [1:0] lh, input logic uv,
                      input logic [31:0] upc, input logic [1:0] uh, input logic ut);
    string req;
    logic eh, et;
    @(negedge clk);
    lk_pc = lpc; lk_hint = lh; up_valid = uv; up_pc = upc; up_hint = uh; up_taken = ut;
    #1;
    eh = exp_hit(lpc, lh);
    et = exp_taken(lpc, lh);
    if (lh == 2'b00)      req = "R1";
    else if (lh == 2'b01) req = "R2";
    else if (!eh)         req = "R3";
    else if (uv && uh[1] && upc[5:2] == lpc[5:2]) req = "R9";
    else                  req = "R7";
    chk(req, lk_taken, et, "lk_taken");
    chk(req, lk_hit, eh, "lk_hit");
    @(posedge clk);
    if (uv && uh[1]) begin
      if (rv[upc[5:2]] && rt[upc[5:2]] == upc[31:6]) begin
        rc[upc[5:2]] = sat(rc[upc[5:2]], ut);
      end else begin
        rv[upc[5:2]] = 1'b1;
        rt[upc[5:2]] = upc[31:6];
        rc[upc[5:2]] = ut ? 2'b10 : 2'b01;
      end
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic [1:0] h, input logic t);
    step(pc, 2'b00, 1'b1, pc, h, t);
  endtask

  task automatic look(input string req, input logic [31:0] pc, input logic [1:0] h,
                      input logic et, input logic eh);
    @(negedge clk);
    lk_pc = pc; lk_hint = h; up_valid = 1'b0;
    #1;
    chk(req, lk_taken, et, "lk_taken");
    chk(req, lk_hit, eh, "lk_hit");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, pb;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin rv[i] = 1'b0; rt[i] = '0; rc[i] = 2'b01; end
    rst_n = 1'b0; lk_pc = '0; lk_hint = 2'b10; up_valid = 1'b0; up_pc = '0;
    up_hint = 2'b00; up_taken = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: every slot empty after reset
    for (int i = 0; i < 16; i++) look("R10", mkpc(26'd5, 4'(i)), 2'b11, 1'b0, 1'b0);

    // R4: static updates leave the table alone
    pa = mkpc(26'd7, 4'd3);
    upd(pa, 2'b00, 1'b1);
    upd(pa, 2'b01, 1'b0);
    look("R4", pa, 2'b11, 1'b0, 1'b0);
    look("R4", pa, 2'b10, 1'b1, 1'b0);

    // R5: seeding on miss
    pa = mkpc(26'd9, 4'd4);
    upd(pa, 2'b10, 1'b1);
    look("R5", pa, 2'b11, 1'b1, 1'b1);
    upd(pa, 2'b10, 1'b0);
    look("R7", pa, 2'b10, 1'b0, 1'b1);
    pa = mkpc(26'd9, 4'd5);
    upd(pa, 2'b11, 1'b0);
    look("R5", pa, 2'b10, 1'b0, 1'b1);

    // R6: saturation at both ends
    pa = mkpc(26'd11, 4'd6);
    repeat (4) upd(pa, 2'b10, 1'b1);
    upd(pa, 2'b10, 1'b0);
    look("R6", pa, 2'b11, 1'b1, 1'b1);
    pa = mkpc(26'd11, 4'd7);
    repeat (4) upd(pa, 2'b11, 1'b0);
    upd(pa, 2'b11, 1'b1);
    look("R6", pa, 2'b10, 1'b0, 1'b1);

    // R1, R2: static hints ignore a hitting slot
    look("R1", pa, 2'b00, 1'b1, 1'b0);
    look("R2", mkpc(26'd11, 4'd6), 2'b01, 1'b0, 1'b0);

    // R8: tag conflict in one slot
    pa = mkpc(26'd1, 4'd8);
    pb = mkpc(26'd2, 4'd8);
    upd(pa, 2'b10, 1'b1);
    look("R8", pb, 2'b11, 1'b0, 1'b0);
    upd(pb, 2'b11, 1'b0);
    look("R8", pb, 2'b10, 1'b0, 1'b1);
    look("R8", pa, 2'b11, 1'b0, 1'b0);

    // R9: lookup during an update of the same slot
    pa = mkpc(26'd3, 4'd9);
    upd(pa, 2'b11, 1'b0);
    step(pa, 2'b10, 1'b1, pa, 2'b10, 1'b1);
    look("R9", pa, 2'b11, 1'b1, 1'b1);

    // random traffic over few tags
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] lp, upx;
      lp  = mkpc(26'($urandom % 3), 4'($urandom % 16));
      upx = ($urandom % 4 == 0) ? lp : mkpc(26'($urandom % 3), 4'($urandom % 16));
      step(lp, 2'($urandom), 1'($urandom), upx, 2'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule